// File: doc/BRIEF.md
# Dual-Master Interrupt Cause Controller

This block keeps one 32-bit interrupt cause word that two bus masters share: a local processor port and a host-bus port. Single-cycle hardware event pulses (three timer expiries, five host-bus parity errors, a memory parity error, master abort, target abort and retry-counter expiry) are caught in sticky cause bits. Two groups of doorbell bits carry software interrupts between the masters: one master sets a doorbell, and only the other master can clear it. One bit changes role with a power-management enable.

Each master owns one 32-bit mask register. Each mask selects which cause bits reach one of two summaries. Each summary also takes in a pending flag from a separate high cause register outside the block. The summaries can be read back in the top two bits of the cause word, and each one drives an active-low, registered interrupt pin. Each master has a plain write/read port with a 2-bit register select. Read data is registered.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt[i]` (i = 0..11) sets cause bit 9+i on the next clock edge. The events, from i=0 upward, are timer 1, timer 2, timer 3, host master-read parity, host slave-write parity, host master-write parity, host slave-read parity, host address parity, memory parity, master abort, target abort and retry expiry. The bit stays set when the pulse ends.
- R2: An event bit is cleared when either master writes the cause word (select 0) with a 0 in that bit position. Writing 1 leaves the bit unchanged. An event pulse in the same cycle as a clear wins, and the bit stays set.
- R3: Bits 25:22 are host-bound doorbells. A processor write of 0 sets the bit. A host write of 0 clears it. A processor write of 0 never clears it, and a write of 1 from either side leaves it unchanged.
- R4: Bits 29:26 are processor-bound doorbells. A host write of 0 sets the bit. A processor write of 0 clears it. A host write of 0 never clears it, and a write of 1 from either side leaves it unchanged.
- R5: When `pm_en` is 1, bit 21 behaves as an event bit that `pm_update` sets and that R2 clears. When `pm_en` is 0, bit 21 behaves as an extra host-bound doorbell under the rules of R3.
- R6: If both masters write 0 to the same doorbell bit in the same cycle, the bit ends up set.
- R7: Read bit 30 equals OR(cause[29:0] & mask0[29:0]) OR `hi_pend[0]`. Read bit 31 uses mask1 and `hi_pend[1]` in the same way. Neither bit can be written.
- R8: `irq0_n` and `irq1_n` are the inverses of read bits 30 and 31. They are registered, so they follow a change in cause, mask or `hi_pend` one clock later.
- R9: Select 1 is mask0 and select 2 is mask1. Only the processor port writes mask0, and only the host port writes mask1. A write to the other master's mask is ignored. Both masters can read both masks.
- R10: Synchronous reset clears the cause bits and both masks and drives both pins high. Cause bits 8:0 always read 0.
- R11: `cpu_rdata` and `host_rdata` are registered. They return the register picked by the select that was present before the last clock edge. Select 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 12 | Hardware event pulses |
| pm_en | input | 1 | Power-management enable for bit 21 |
| pm_update | input | 1 | Host updated the power-state field |
| hi_pend | input | 2 | Masked pending flags from the high cause register |
| cpu_we | input | 1 | Processor write strobe |
| cpu_sel | input | 2 | Processor register select |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, registered |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| irq0_n | output | 1 | Active-low interrupt from summary 0 |
| irq1_n | output | 1 | Active-low interrupt from summary 1 |

## Verification
The assertions assume that `rst` is held for at least one edge before any traffic. They also assume that `cpu_sel` and `host_sel` always carry a known 2-bit value, and that event and write inputs are free to change on any cycle, including cycles where they collide. The stimulus drives every input at the falling edge. It keeps the selects inside the four legal codes, and it chooses write data with only a few zero bits, so that set, clear and collision cases all occur often instead of most bits being cleared at once.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int WORD_W   = 32;
  localparam int CAUSE_W  = 30;
  localparam int EVT_LSB  = 9;
  localparam int EVT_N    = 12;
  localparam int PM_BIT   = 21;
  localparam int HDB_LSB  = 22;
  localparam int CDB_LSB  = 26;
  localparam int DB_N     = 4;
  localparam int SUM0_BIT = 30;
  localparam int SUM1_BIT = 31;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK0 = 2'd1,
    SEL_MASK1 = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_bits.sv
module irq_cause_bits
  import irq_cause_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [EVT_N-1:0]   evt,
  input  logic               pm_en,
  input  logic               pm_update,
  input  logic               cpu_wr,
  input  logic [CAUSE_W-1:0] cpu_wdata,
  input  logic               host_wr,
  input  logic [CAUSE_W-1:0] host_wdata,
  output logic [CAUSE_W-1:0] cause
);
  localparam int EVT_MSB = EVT_LSB + EVT_N - 1;
  localparam int HDB_MSB = HDB_LSB + DB_N - 1;
  localparam int CDB_MSB = CDB_LSB + DB_N - 1;

  logic [CAUSE_W-1:0] cpu_zero, host_zero, nxt;

  assign cpu_zero  = {CAUSE_W{cpu_wr}}  & ~cpu_wdata;
  assign host_zero = {CAUSE_W{host_wr}} & ~host_wdata;

  for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
    if (b < EVT_LSB) begin : g_rsv
      assign nxt[b] = 1'b0;
    end else if (b <= EVT_MSB) begin : g_evt
      assign nxt[b] = evt[b-EVT_LSB] | (cause[b] & ~cpu_zero[b] & ~host_zero[b]);
    end else if (b == PM_BIT) begin : g_pm
      assign nxt[b] = pm_en ? (pm_update | (cause[b] & ~cpu_zero[b] & ~host_zero[b]))
                            : (cpu_zero[b] | (cause[b] & ~host_zero[b]));
    end else if (b <= HDB_MSB) begin : g_hdb
      assign nxt[b] = cpu_zero[b] | (cause[b] & ~host_zero[b]);
    end else begin : g_cdb
      assign nxt[b] = host_zero[b] | (cause[b] & ~cpu_zero[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cause <= '0;
    else     cause <= nxt;
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((cause[EVT_MSB:EVT_LSB] & $past(evt)) == $past(evt))); // R1
  AST_EVT_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr && !host_wr) |=>
      ((cause[EVT_MSB:EVT_LSB] & $past(cause[EVT_MSB:EVT_LSB])) == $past(cause[EVT_MSB:EVT_LSB]))); // R2
  AST_HDB_SET: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && (~cpu_wdata[HDB_MSB:HDB_LSB] != '0)) |=>
      ((cause[HDB_MSB:HDB_LSB] & $past(~cpu_wdata[HDB_MSB:HDB_LSB])) == $past(~cpu_wdata[HDB_MSB:HDB_LSB]))); // R3
  AST_CDB_SET: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (~host_wdata[CDB_MSB:CDB_LSB] != '0)) |=>
      ((cause[CDB_MSB:CDB_LSB] & $past(~host_wdata[CDB_MSB:CDB_LSB])) == $past(~host_wdata[CDB_MSB:CDB_LSB]))); // R4
  AST_PM_LATCH: assert property (@(posedge clk) disable iff (rst)
    (pm_en && pm_update) |=> cause[PM_BIT]); // R5
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R9
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cause,
  input  logic [W-1:0] mask,
  input  logic         hi_pend,
  output logic         sum,
  output logic         irq_n
);
  assign sum = (|(cause & mask)) | hi_pend;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~sum;
  end

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((mask == '0) && !hi_pend) |=> irq_n); // R8
  AST_PIN_HIGH_PEND: assert property (@(posedge clk) disable iff (rst)
    hi_pend |=> !irq_n); // R8
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       evt,
  input  logic              pm_en,
  input  logic              pm_update,
  input  logic [1:0]        hi_pend,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_sel,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq0_n,
  output logic              irq1_n
);
  logic [CAUSE_W-1:0] cause;
  logic [WORD_W-1:0]  mask0, mask1;
  logic               sum0, sum1;
  logic [WORD_W-1:0]  cause_word;
  logic               cpu_cause_wr, host_cause_wr;

  assign cpu_cause_wr  = cpu_we  && (reg_sel_e'(cpu_sel)  == SEL_CAUSE);
  assign host_cause_wr = host_we && (reg_sel_e'(host_sel) == SEL_CAUSE);

  irq_cause_bits u_bits (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .pm_en      (pm_en),
    .pm_update  (pm_update),
    .cpu_wr     (cpu_cause_wr),
    .cpu_wdata  (cpu_wdata[CAUSE_W-1:0]),
    .host_wr    (host_cause_wr),
    .host_wdata (host_wdata[CAUSE_W-1:0]),
    .cause      (cause)
  );

  irq_mask_reg #(.W(WORD_W)) u_mask0 (
    .clk   (clk),
    .rst   (rst),
    .we    (cpu_we && (reg_sel_e'(cpu_sel) == SEL_MASK0)),
    .wdata (cpu_wdata),
    .q     (mask0)
  );

  irq_mask_reg #(.W(WORD_W)) u_mask1 (
    .clk   (clk),
    .rst   (rst),
    .we    (host_we && (reg_sel_e'(host_sel) == SEL_MASK1)),
    .wdata (host_wdata),
    .q     (mask1)
  );

  irq_summary #(.W(CAUSE_W)) u_sum0 (
    .clk     (clk),
    .rst     (rst),
    .cause   (cause),
    .mask    (mask0[CAUSE_W-1:0]),
    .hi_pend (hi_pend[0]),
    .sum     (sum0),
    .irq_n   (irq0_n)
  );

  irq_summary #(.W(CAUSE_W)) u_sum1 (
    .clk     (clk),
    .rst     (rst),
    .cause   (cause),
    .mask    (mask1[CAUSE_W-1:0]),
    .hi_pend (hi_pend[1]),
    .sum     (sum1),
    .irq_n   (irq1_n)
  );

  assign cause_word = {sum1, sum0, cause};

  function automatic logic [WORD_W-1:0] pick(input logic [SEL_W-1:0] sel);
    case (reg_sel_e'(sel))
      SEL_CAUSE: pick = cause_word;
      SEL_MASK0: pick = mask0;
      SEL_MASK1: pick = mask1;
      default:   pick = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      cpu_rdata  <= pick(cpu_sel);
      host_rdata <= pick(host_sel);
    end
  end

  AST_MASK0_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && (reg_sel_e'(cpu_sel) == SEL_MASK0)) |=> $stable(mask0)); // R9
  AST_MASK1_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(host_we && (reg_sel_e'(host_sel) == SEL_MASK1)) |=> $stable(mask1)); // R9
  AST_SEL_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(cpu_sel) == SEL_NONE) |=> (cpu_rdata == '0)); // R11
  AST_RSV_LOW: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(host_sel) == SEL_CAUSE) |=> (host_rdata[8:0] == '0)); // R10
endmodule

// File: tb/test_irq_cause_ctrl.sv
module test_irq_cause_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] evt = '0;
  logic        pm_en = 1'b0, pm_update = 1'b0;
  logic [1:0]  hi_pend = '0;
  logic        cpu_we = 1'b0, host_we = 1'b0;
  logic [1:0]  cpu_sel = '0, host_sel = '0;
  logic [31:0] cpu_wdata = '1, host_wdata = '1;
  logic [31:0] cpu_rdata, host_rdata;
  logic        irq0_n, irq1_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [29:0] m_cause = '0;
  logic [31:0] m_mask0 = '0, m_mask1 = '0;

  always #10 clk = ~clk;

  irq_cause_ctrl i_irq_cause_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .pm_en(pm_en), .pm_update(pm_update),
    .hi_pend(hi_pend), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  function automatic logic summ(input logic [29:0] c, input logic [31:0] m, input logic h);
    return ((c & m[29:0]) != '0) || h;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return {summ(m_cause, m_mask1, hi_pend[1]), summ(m_cause, m_mask0, hi_pend[0]), m_cause};
      2'd1: return m_mask0;
      2'd2: return m_mask1;
      default: return 32'd0;
    endcase
  endfunction

  // Next cause value from the requirement rules R1..R6
  function automatic logic [29:0] model_next();
    logic [29:0] cz, hz, n;
    cz = (cpu_we  && cpu_sel  == 2'd0) ? ~cpu_wdata[29:0]  : '0;
    hz = (host_we && host_sel == 2'd0) ? ~host_wdata[29:0] : '0;
    n = '0;
    for (int b = 9; b <= 20; b++)
      n[b] = evt[b-9] || (m_cause[b] && !cz[b] && !hz[b]);
    if (pm_en) n[21] = pm_update || (m_cause[21] && !cz[21] && !hz[21]);
    else       n[21] = cz[21] || (m_cause[21] && !hz[21]);
    for (int b = 22; b <= 25; b++) n[b] = cz[b] || (m_cause[b] && !hz[b]);
    for (int b = 26; b <= 29; b++) n[b] = hz[b] || (m_cause[b] && !cz[b]);
    return n;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [31:0] e_c, e_h;
    logic e_i0, e_i1;
    logic [29:0] n;
    e_c = model_read(cpu_sel);
    e_h = model_read(host_sel);
    e_i0 = !summ(m_cause, m_mask0, hi_pend[0]);
    e_i1 = !summ(m_cause, m_mask1, hi_pend[1]);
    n = model_next();
    if (cpu_we  && cpu_sel  == 2'd1) m_mask0 = cpu_wdata;
    if (host_we && host_sel == 2'd2) m_mask1 = host_wdata;
    @(posedge clk);
    @(negedge clk);
    m_cause = n;
    chk(tag, "cpu_rdata", cpu_rdata, e_c);
    chk(tag, "host_rdata", host_rdata, e_h);
    chk(tag, "irq0_n", {31'd0, irq0_n}, {31'd0, e_i0});
    chk(tag, "irq1_n", {31'd0, irq1_n}, {31'd0, e_i1});
    evt = '0; pm_update = 1'b0; cpu_we = 1'b0; host_we = 1'b0;
    cpu_wdata = '1; host_wdata = '1;
  endtask

  task automatic wr_cpu(input logic [1:0] s, input logic [31:0] d);
    cpu_we = 1'b1; cpu_sel = s; cpu_wdata = d;
  endtask

  task automatic wr_host(input logic [1:0] s, input logic [31:0] d);
    host_we = 1'b1; host_sel = s; host_wdata = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    cpu_sel = 2'd0; host_sel = 2'd1;
    step("R10");
    cpu_sel = 2'd2; host_sel = 2'd0;
    step("R10");
    // R1 each event individually, read from cause
    cpu_sel = 2'd0; host_sel = 2'd0;
    for (int i = 0; i < 12; i++) begin
      evt = 12'd1 << i;
      step("R1");
    end
    step("R1");
    // R2 write 1 keeps, write 0 clears, event beats clear
    wr_host(2'd0, 32'hFFFF_FFFF);
    step("R2");
    evt = 12'h001;
    wr_cpu(2'd0, ~32'h0000_0E00);
    step("R2");
    wr_host(2'd0, ~32'h001F_F000);
    step("R2");
    step("R2");
    // R3 host-bound doorbell
    wr_cpu(2'd0, ~32'h0040_0000);
    step("R3");
    wr_cpu(2'd0, ~32'h0040_0000);
    step("R3");
    wr_host(2'd0, 32'hFFFF_FFFF);
    step("R3");
    wr_host(2'd0, ~32'h03C0_0000);
    step("R3");
    step("R3");
    // R4 processor-bound doorbell
    wr_host(2'd0, ~32'h2400_0000);
    step("R4");
    wr_host(2'd0, ~32'h2000_0000);
    step("R4");
    wr_cpu(2'd0, ~32'h2000_0000);
    step("R4");
    step("R4");
    // R5 bit 21 in both modes
    pm_en = 1'b1; pm_update = 1'b1;
    step("R5");
    wr_cpu(2'd0, ~32'h0020_0000);
    step("R5");
    pm_en = 1'b0;
    wr_cpu(2'd0, ~32'h0020_0000);
    step("R5");
    wr_host(2'd0, ~32'h0020_0000);
    step("R5");
    step("R5");
    // R6 simultaneous set and clear
    wr_cpu(2'd0, ~32'h0080_0000);
    wr_host(2'd0, ~32'h0080_0000);
    step("R6");
    wr_cpu(2'd0, ~32'h0800_0000);
    wr_host(2'd0, ~32'h0800_0000);
    step("R6");
    step("R6");
    // R9 mask ownership
    wr_host(2'd1, 32'hFFFF_FFFF);
    cpu_sel = 2'd1;
    step("R9");
    wr_cpu(2'd2, 32'hFFFF_FFFF);
    host_sel = 2'd2;
    step("R9");
    wr_cpu(2'd1, 32'h0080_0000);
    wr_host(2'd2, 32'h2000_0000);
    step("R9");
    step("R9");
    // R7 summaries, read-only top bits
    cpu_sel = 2'd0; host_sel = 2'd0;
    wr_cpu(2'd0, 32'hFFFF_FFFF);
    step("R7");
    hi_pend = 2'b10;
    step("R7");
    wr_host(2'd0, ~32'h0080_0000);
    hi_pend = 2'b00;
    step("R8");
    step("R8");
    // R11 select 3 reads zero
    cpu_sel = 2'd3; host_sel = 2'd3;
    step("R11");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      evt = 12'($urandom & $urandom & $urandom);
      pm_en = ($urandom % 4) == 0;
      pm_update = ($urandom % 3) == 0;
      hi_pend = 2'(($urandom % 8) == 0 ? $urandom : 0);
      cpu_sel = 2'($urandom);
      host_sel = 2'($urandom);
      cpu_we = $urandom % 2;
      host_we = $urandom % 2;
      cpu_wdata = ~($urandom & $urandom & $urandom);
      host_wdata = ~($urandom & $urandom & $urandom);
      if (cpu_sel == 2'd1 && cpu_we) cpu_wdata = $urandom;
      if (host_sel == 2'd2 && host_we) host_wdata = $urandom;
      step("R7");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule